// File: doc/BRIEF.md
# Conditioned-Input Arithmetic Micro-Operation Unit

This block performs register-transfer arithmetic on two source operands using a single carry-lookahead adder. A 3-bit operation code controls three things: what drives the adder's A port, what drives its B port, and the carry-in. From those settings the one adder produces add, subtract, increment, decrement, one's complement and two's complement. There is no separate incrementer and no separate negator.

The adder computes per-bit generate and propagate terms. It works in fixed-size groups, and a second lookahead level forms the carry into each group from the group generate and group propagate signals, so no carry ripples. The sum, a carry-out flag and a signed overflow flag are loaded into a destination register at a rising clock edge, but only when the transfer enable was high during the cycle that edge ends. Otherwise the register holds its value.

Top module: `amu_core`

## Requirements
- R1: Code 3'b000 loads the destination with `src_a + src_b` modulo 2^WIDTH.
- R2: Code 3'b001 loads `src_a - src_b`. The adder sees A = src_a, B = the bitwise inverse of src_b and carry-in = 1, so `carry_q` = 1 means no borrow.
- R3: Code 3'b010 loads `src_a + 1`. The adder sees A = src_a, B = all zeros and carry-in = 1.
- R4: Code 3'b011 loads `src_a - 1`. The adder sees A = src_a, B = all ones and carry-in = 0.
- R5: Code 3'b100 loads `~src_b`. The adder sees A = all zeros, B = ~src_b and carry-in = 0. `src_a` has no effect.
- R6: Code 3'b101 loads `-src_b`. The adder sees A = all zeros, B = ~src_b and carry-in = 1. `src_a` has no effect.
- R7: Codes 3'b110 and 3'b111 load `src_a` unchanged, with both flags 0.
- R8: When `xfer_en` is 0 at a rising edge, `dest_q`, `carry_q` and `ovf_q` keep their values.
- R9: When `rst` is high at a rising edge, `dest_q`, `carry_q` and `ovf_q` are cleared to 0. Reset takes priority over `xfer_en`.
- R10: `carry_q` is loaded with the carry out of the most significant bit of the adder, for the A, B and carry-in of the selected code.
- R11: `ovf_q` is loaded with 1 exactly when adder inputs A and B have equal sign bits and the sum's sign bit differs from them. This is the same as the carry into the MSB XOR the carry out of the MSB.
- R12: WIDTH defaults to 16 and GROUP to 4. Carries crossing every group boundary, including a carry that runs the full width, give exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en | input | 1 | Transfer control function; loads the destination at the edge ending the cycle |
| op_sel | input | 3 | Micro-operation code |
| src_a | input | WIDTH | First source register value |
| src_b | input | WIDTH | Second source register value |
| dest_q | output | WIDTH | Destination register |
| carry_q | output | 1 | Registered adder carry-out |
| ovf_q | output | 1 | Registered signed overflow |

## Verification
The clocked assertions assume that `op_sel`, `src_a`, `src_b` and `xfer_en` are known and stable at each rising edge. They also assume that a transfer result is judged one edge after the enable, except when reset intervenes. The combinational adder checks assume fully known operands. To stay within these assumptions, the stimulus drives every input on the falling edge, holds it through the next rising edge, and releases reset only on a falling edge. It also never leaves an input undriven after reset.

// File: rtl/amu_pkg.sv
package amu_pkg;

   localparam int OP_W   = 3;
   localparam int LA_MAX = 64;

   typedef logic [OP_W-1:0] amu_op_t;

   localparam amu_op_t OP_ADD  = 3'b000;
   localparam amu_op_t OP_SUB  = 3'b001;
   localparam amu_op_t OP_INC  = 3'b010;
   localparam amu_op_t OP_DEC  = 3'b011;
   localparam amu_op_t OP_ONES = 3'b100;
   localparam amu_op_t OP_TWOS = 3'b101;

   // Carry into position 'upto' from generate/propagate terms, flattened
   // into sum-of-products form so no carry ripples through earlier positions.
   function automatic logic lookahead(input logic [LA_MAX-1:0] gv,
                                      input logic [LA_MAX-1:0] pv,
                                      input logic              ci,
                                      input int                upto);
      logic acc;
      logic term;
      acc = ci;
      for (int k = 0; k < LA_MAX; k++) begin
         if (k < upto) acc = acc & pv[k];
      end
      for (int j = 0; j < LA_MAX; j++) begin
         if (j < upto) begin
            term = gv[j];
            for (int k = 0; k < LA_MAX; k++) begin
               if (k > j && k < upto) term = term & pv[k];
            end
            acc = acc | term;
         end
      end
      return acc;
   endfunction

endpackage

// File: rtl/amu_operand_cond.sv
module amu_operand_cond
   import amu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  amu_op_t            op_sel,
   input  logic [WIDTH-1:0]   src_a,
   input  logic [WIDTH-1:0]   src_b,
   output logic [WIDTH-1:0]   opa,
   output logic [WIDTH-1:0]   opb,
   output logic               cin
);

   logic a_keep;     // 1: A driven by src_a, 0: A forced to zero
   logic b_keep;     // 1: B derived from src_b, 0: from all zeros
   logic b_inv;      // XOR control applied to every B bit

   always_comb begin
      a_keep = 1'b1;
      b_keep = 1'b0;
      b_inv  = 1'b0;
      cin    = 1'b0;
      unique case (op_sel)
         OP_ADD:  begin b_keep = 1'b1; b_inv = 1'b0; cin = b_inv; end
         OP_SUB:  begin b_keep = 1'b1; b_inv = 1'b1; cin = b_inv; end
         OP_INC:  begin cin = 1'b1; end
         OP_DEC:  begin b_inv = 1'b1; end
         OP_ONES: begin a_keep = 1'b0; b_keep = 1'b1; b_inv = 1'b1; end
         OP_TWOS: begin a_keep = 1'b0; b_keep = 1'b1; b_inv = 1'b1; cin = 1'b1; end
         default: begin end   // pass src_a: A + 0 + 0
      endcase
   end

   assign opa = a_keep ? src_a : '0;
   assign opb = (b_keep ? src_b : '0) ^ {WIDTH{b_inv}};

   // Complement codes must ignore src_a entirely (R5, R6).
   always_comb begin
      if (!$isunknown(op_sel) && (op_sel == OP_ONES || op_sel == OP_TWOS))
         assert_cmpl_a_zero_R5: assert (opa == '0);
   end

   // Subtract presents the inverted second operand with carry-in set (R2).
   always_comb begin
      if (!$isunknown({op_sel, src_b}) && op_sel == OP_SUB)
         assert_sub_inputs_R2: assert (opb == ~src_b && cin);
   end

endmodule

// File: rtl/amu_cla_group.sv
module amu_cla_group
   import amu_pkg::*;
#(
   parameter int GW = 4
) (
   input  logic [GW-1:0] a,
   input  logic [GW-1:0] b,
   input  logic          cin,
   output logic [GW-1:0] sum,
   output logic          grp_g,
   output logic          grp_p
);

   logic [GW-1:0] g;
   logic [GW-1:0] p;
   logic [GW-1:0] c;

   assign g = a & b;
   assign p = a ^ b;

   always_comb begin
      c[0] = cin;
      for (int i = 1; i < GW; i++)
         c[i] = lookahead(LA_MAX'(g), LA_MAX'(p), cin, i);
   end

   assign sum   = p ^ c;
   assign grp_g = lookahead(LA_MAX'(g), LA_MAX'(p), 1'b0, GW);
   assign grp_p = &p;

endmodule

// File: rtl/amu_cla.sv
module amu_cla
   import amu_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int GROUP = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   localparam int NG  = WIDTH / GROUP;
   localparam int MSB = WIDTH - 1;

   if (GROUP < 1 || GROUP > LA_MAX) begin : g_bad_group
      $error("amu_cla: GROUP out of range");
   end
   if (WIDTH % GROUP != 0) begin : g_bad_split
      $error("amu_cla: WIDTH must be a multiple of GROUP");
   end
   if (NG < 1 || NG > LA_MAX) begin : g_bad_count
      $error("amu_cla: group count out of range");
   end

   logic [NG-1:0] gg;
   logic [NG-1:0] gp;
   logic [NG:0]   gc;
   logic          c_msb_in;

   // Second lookahead level: carry into each group from group terms.
   always_comb begin
      gc[0] = cin;
      for (int k = 1; k <= NG; k++)
         gc[k] = lookahead(LA_MAX'(gg), LA_MAX'(gp), cin, k);
   end

   for (genvar k = 0; k < NG; k++) begin : g_grp
      amu_cla_group #(.GW(GROUP)) u_grp (
         .a     (a[k*GROUP +: GROUP]),
         .b     (b[k*GROUP +: GROUP]),
         .cin   (gc[k]),
         .sum   (sum[k*GROUP +: GROUP]),
         .grp_g (gg[k]),
         .grp_p (gp[k])
      );
   end

   assign cout     = gc[NG];
   assign c_msb_in = sum[MSB] ^ a[MSB] ^ b[MSB];
   assign ovf      = c_msb_in ^ cout;

   // Lookahead tree agrees with plain arithmetic (R10, R12).
   always_comb begin
      if (!$isunknown({a, b, cin}))
         assert_sum_R12: assert ({cout, sum} ==
            ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
   end

endmodule

// File: rtl/amu_core.sv
module amu_core
   import amu_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter int GROUP     = 4,
   parameter bit HAS_FLAGS = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             xfer_en,
   input  logic [2:0]       op_sel,
   input  logic [WIDTH-1:0] src_a,
   input  logic [WIDTH-1:0] src_b,
   output logic [WIDTH-1:0] dest_q,
   output logic             carry_q,
   output logic             ovf_q
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("amu_core: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] opa;
   logic [WIDTH-1:0] opb;
   logic             cin;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             ovf;

   amu_operand_cond #(.WIDTH(WIDTH)) u_cond (
      .op_sel (op_sel),
      .src_a  (src_a),
      .src_b  (src_b),
      .opa    (opa),
      .opb    (opb),
      .cin    (cin)
   );

   amu_cla #(.WIDTH(WIDTH), .GROUP(GROUP)) u_cla (
      .a    (opa),
      .b    (opb),
      .cin  (cin),
      .sum  (sum),
      .cout (cout),
      .ovf  (ovf)
   );

   always_ff @(posedge clk) begin
      if (rst)          dest_q <= '0;
      else if (xfer_en) dest_q <= sum;
   end

   if (HAS_FLAGS) begin : g_flags
      always_ff @(posedge clk) begin
         if (rst) begin
            carry_q <= 1'b0;
            ovf_q   <= 1'b0;
         end else if (xfer_en) begin
            carry_q <= cout;
            ovf_q   <= ovf;
         end
      end

      assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
         !xfer_en |=> $stable(carry_q) && $stable(ovf_q));

      assert_flag_reset_R9: assert property (@(posedge clk)
         rst |=> !carry_q && !ovf_q);

      assert_pass_flags_R7: assert property (@(posedge clk) disable iff (rst)
         xfer_en && op_sel[2:1] == 2'b11 |=> !carry_q && !ovf_q);

      assert_add_ovf_R11: assert property (@(posedge clk) disable iff (rst)
         xfer_en && op_sel == OP_ADD |=>
            ovf_q == ($past(src_a[MSB] == src_b[MSB]) &&
                      dest_q[MSB] != $past(src_a[MSB])));
   end else begin : g_no_flags
      assign carry_q = 1'b0;
      assign ovf_q   = 1'b0;
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !xfer_en |=> $stable(dest_q));

   assert_reset_R9: assert property (@(posedge clk)
      rst |=> dest_q == '0);

   assert_add_R1: assert property (@(posedge clk) disable iff (rst)
      xfer_en && op_sel == OP_ADD |=> dest_q == $past(WIDTH'(src_a + src_b)));

   assert_sub_R2: assert property (@(posedge clk) disable iff (rst)
      xfer_en && op_sel == OP_SUB |=> dest_q == $past(WIDTH'(src_a - src_b)));

   assert_pass_R7: assert property (@(posedge clk) disable iff (rst)
      xfer_en && op_sel[2:1] == 2'b11 |=> dest_q == $past(src_a));

endmodule

// File: tb/tb_amu_core.sv
`timescale 1ns/1ps
module tb_amu_core;

   localparam int W = 16;
   localparam int NV = 18;

   logic         clk = 1'b0;
   logic         rst;
   logic         xfer_en;
   logic [2:0]   op_sel;
   logic [W-1:0] src_a;
   logic [W-1:0] src_b;
   logic [W-1:0] dest_q;
   logic         carry_q;
   logic         ovf_q;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   amu_core dut (
      .clk(clk), .rst(rst), .xfer_en(xfer_en), .op_sel(op_sel),
      .src_a(src_a), .src_b(src_b),
      .dest_q(dest_q), .carry_q(carry_q), .ovf_q(ovf_q)
   );

   // {op, src_a, src_b, expected result}
   localparam logic [50:0] TBL [NV] = '{
      {3'd0, 16'h1234, 16'h0111, 16'h1345},
      {3'd0, 16'hFFFF, 16'h0001, 16'h0000},
      {3'd0, 16'h7FFF, 16'h0001, 16'h8000},
      {3'd1, 16'h0005, 16'h0003, 16'h0002},
      {3'd1, 16'h0003, 16'h0005, 16'hFFFE},
      {3'd1, 16'h8000, 16'h0001, 16'h7FFF},
      {3'd2, 16'h00FF, 16'h5555, 16'h0100},
      {3'd2, 16'hFFFF, 16'h0000, 16'h0000},
      {3'd2, 16'h7FFF, 16'hAAAA, 16'h8000},
      {3'd3, 16'h0000, 16'h1111, 16'hFFFF},
      {3'd3, 16'h0100, 16'h0000, 16'h00FF},
      {3'd3, 16'h8000, 16'h0000, 16'h7FFF},
      {3'd4, 16'hDEAD, 16'h00F0, 16'hFF0F},
      {3'd5, 16'hDEAD, 16'h0001, 16'hFFFF},
      {3'd5, 16'h4321, 16'h0000, 16'h0000},
      {3'd5, 16'h0000, 16'h8000, 16'h8000},
      {3'd6, 16'hBEEF, 16'h1234, 16'hBEEF},
      {3'd7, 16'h1357, 16'hFFFF, 16'h1357}
   };

   // Returns {ovf, carry, result} from the requirement's A/B/carry-in.
   function automatic logic [W+1:0] model(input logic [2:0] op,
                                          input logic [W-1:0] a,
                                          input logic [W-1:0] b);
      logic [W-1:0] x, y, s;
      logic         ci;
      logic [W:0]   full;
      logic         v;
      case (op)
         3'd0: begin x = a;  y = b;   ci = 1'b0; end
         3'd1: begin x = a;  y = ~b;  ci = 1'b1; end
         3'd2: begin x = a;  y = '0;  ci = 1'b1; end
         3'd3: begin x = a;  y = '1;  ci = 1'b0; end
         3'd4: begin x = '0; y = ~b;  ci = 1'b0; end
         3'd5: begin x = '0; y = ~b;  ci = 1'b1; end
         default: begin x = a; y = '0; ci = 1'b0; end
      endcase
      full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
      s    = full[W-1:0];
      v    = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
      return {v, full[W], s};
   endfunction

   function automatic string req_of(input logic [2:0] op);
      case (op)
         3'd0: return "R1/R10/R11";
         3'd1: return "R2/R10/R11";
         3'd2: return "R3/R10/R11";
         3'd3: return "R4/R10/R11";
         3'd4: return "R5/R10/R11";
         3'd5: return "R6/R10/R11";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string req, input logic [W+1:0] exp);
      n_chk++;
      if ({ovf_q, carry_q, dest_q} !== exp) begin
         n_bad++;
         $display("FAIL %s: got ovf=%0b c=%0b q=%h expected ovf=%0b c=%0b q=%h",
                  req, ovf_q, carry_q, dest_q, exp[W+1], exp[W], exp[W-1:0]);
      end
   endtask

   // Drive on falling edge; the rising edge loads; sample at next falling edge.
   task automatic apply(input logic en, input logic [2:0] op,
                        input logic [W-1:0] a, input logic [W-1:0] b);
      xfer_en = en; op_sel = op; src_a = a; src_b = b;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [W+1:0] prev;
      logic [15:0]  lfsr;
      rst = 1'b1; xfer_en = 1'b0; op_sel = '0; src_a = '0; src_b = '0;
      repeat (3) @(negedge clk);
      check("R9 reset state", '0);
      rst = 1'b0;

      // Table walk (R1..R7, R10, R11)
      for (int i = 0; i < NV; i++) begin
         logic [2:0]   op;
         logic [W-1:0] a, b, r;
         logic [W+1:0] m;
         {op, a, b, r} = TBL[i];
         apply(1'b1, op, a, b);
         m = model(op, a, b);
         check(req_of(op), {m[W+1:W], r});
         if (m[W-1:0] !== r) begin
            n_bad++;
            $display("FAIL table row %0d: got model %h expected %h", i, m[W-1:0], r);
         end
      end

      // R8: enable low, inputs change, outputs hold
      prev = {ovf_q, carry_q, dest_q};
      apply(1'b0, 3'd0, 16'h7FFF, 16'h7FFF);
      check("R8 hold", prev);
      apply(1'b0, 3'd5, 16'h0000, 16'h0001);
      check("R8 hold", prev);

      // R12: carries across group boundaries and the full width
      apply(1'b1, 3'd0, 16'h0FFF, 16'h0001);
      check("R12 group carry", {2'b00, 16'h1000});
      apply(1'b1, 3'd0, 16'h00FF, 16'hFF01);
      check("R12 full-width carry", {2'b01, 16'h0000});
      apply(1'b1, 3'd2, 16'h0FFF, 16'h0000);
      check("R12 R3 increment chain", {2'b00, 16'h1000});

      // R11 with negative operands
      apply(1'b1, 3'd0, 16'h8000, 16'h8000);
      check("R11 negative overflow", {2'b11, 16'h0000});

      // R9: reset wins over enable
      rst = 1'b1;
      apply(1'b1, 3'd0, 16'h7FFF, 16'h0001);
      check("R9 reset priority", '0);
      rst = 1'b0;

      // Pseudo-random sweep over all codes
      lfsr = 16'hACE1;
      for (int i = 0; i < 200; i++) begin
         logic [2:0]   op;
         logic [W-1:0] a, b;
         op = lfsr[2:0];
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = lfsr;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         b = lfsr;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         apply(1'b1, op, a, b);
         check(req_of(op), model(op, a, b));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule